// File: doc/BRIEF.md
# Variable-Range Translation Buffer with Pinned Slots

This block is a small fully associative translation buffer. Each entry maps one aligned virtual range to a physical base. The range is the base page (4 KiB by default) multiplied by a power of four. A single command port inserts entries, purges ranges, purges everything and manages a set of low-numbered pinned slots. A separate lookup port searches all entries at once and returns the translated physical address together with the entry's attribute byte. Checking permissions and mapping address modes are left to the surrounding logic.

Any command that has to visit every entry walks the table one slot per cycle and holds `busy` while it runs. During that time lookups report a miss and new commands are ignored. The pinned slots are written and cleared only by the slot-addressed commands and by the pinned purge-all, so they hold long-lived mappings that survive the ordinary purges. Unpinned slots are allocated from a free mask, taking the lowest free index first. When no slot is free, a round-robin pointer picks the victim from the unpinned slots.

Top module: `vr_tlb`

## Requirements
- R1: An insert or range purge with size code `cmd_size`=k covers 2^(12+2k) bytes. The start is `cmd_va` aligned down to that size, the end is start+size−1, and the stored physical base of an insert is `cmd_pa` aligned down to the same size. A size that reaches the full address width covers every address.
- R2: A lookup hits when some valid entry satisfies start ≤ `lk_va` ≤ end. `lk_pa` then equals the entry's physical base plus (`lk_va` − start), and `lk_attr` is the entry's stored attributes.
- R3: When several valid entries hit, the one with the lowest slot index provides `lk_pa` and `lk_attr`.
- R4: Insert (`cmd_op`=0) first removes every unpinned entry that overlaps the new range. Pinned entries that overlap it are kept.
- R5: An insert takes the lowest free unpinned slot. When none is free, it takes the round-robin slot, and the pointer then advances. The pointer wraps to the first unpinned slot when it would pass the last slot.
- R6: Range purge (`cmd_op`=1) removes every overlapping unpinned entry and leaves pinned entries intact.
- R7: Purge-all (`cmd_op`=2) removes every unpinned entry, returns all unpinned slots to the free mask and resets the round-robin pointer to the first unpinned slot. Valid pinned entries are kept.
- R8: Pinned insert (`cmd_op`=3) writes slot `cmd_slot`, replacing any previous occupant. The range starts at the page-aligned `cmd_va` and spans `cmd_len` pages. The stored attributes are `cmd_attr` with bit 1 (trap) forced to 0 and bit 0 (dirty) forced to 1.
- R9: A pinned insert or pinned purge whose `cmd_slot` is at or beyond the pinned count, or any `cmd_op` of 6 or 7, completes with `cmd_err`=1 and changes no entry.
- R10: Pinned purge (`cmd_op`=4) clears one pinned slot. Pinned purge-all (`cmd_op`=5) clears every pinned slot and leaves unpinned entries intact.
- R11: Commands 0, 1, 2 and 5 hold `busy` for at most ENTRIES+1 cycles. While `busy` is high, `lk_hit` is 0 and any command presented is ignored.
- R12: `cmd_done` pulses for one cycle when a command completes, and `busy` is low during that pulse. A lookup in that same cycle already sees the new table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 3 | Command code (0..5 valid) |
| cmd_va | input | VA_W | Virtual address of the command |
| cmd_pa | input | PA_W | Physical base for inserts |
| cmd_size | input | 4 | Size code, range = page << 2k |
| cmd_slot | input | SLOT_W | Pinned slot index |
| cmd_len | input | LEN_W | Pinned entry length in pages |
| cmd_attr | input | ATTR_W | Attribute byte to store |
| busy | output | 1 | Walk in progress |
| cmd_done | output | 1 | Command-complete pulse |
| cmd_err | output | 1 | Invalid-argument status, valid with cmd_done |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address |
| lk_attr | output | ATTR_W | Attributes of the winning entry |

## Verification
A lookup and a running table walk can fall in the same cycle. A lookup can also fall in the same cycle as the completion of a command. The bench starts a range purge and, while `busy` is high, presents an address that is still mapped. It expects a miss together with `busy`, and it also offers a pinned insert in that window, which must leave no trace afterwards. Right after each command it looks up the freshly changed ranges and scores every result against a queue of independently computed expectations.

// File: rtl/vr_tlb.sv
module vr_tlb #(
  parameter int ENTRIES = 16,
  parameter int PINNED  = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int ATTR_W  = 8,
  parameter int LEN_W   = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [PA_W-1:0]   cmd_pa,
  input  logic [3:0]        cmd_size,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [ATTR_W-1:0] cmd_attr,
  output logic              busy,
  output logic              cmd_done,
  output logic              cmd_err,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic [PA_W-1:0]   lk_pa,
  output logic [ATTR_W-1:0] lk_attr
);
  localparam logic [2:0] OP_INS = 3'd0, OP_PRG = 3'd1, OP_ALL = 3'd2,
                         OP_PINS = 3'd3, OP_PPRG = 3'd4, OP_PALL = 3'd5;
  localparam logic [ENTRIES-1:0] UNPIN = ~((ENTRIES)'((1 << PINNED) - 1));

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_FIN} state_t;
  state_t st;

  logic [VA_W-1:0]   e_lo [ENTRIES];
  logic [VA_W-1:0]   e_hi [ENTRIES];
  logic [PA_W-1:0]   e_pa [ENTRIES];
  logic [ATTR_W-1:0] e_at [ENTRIES];
  logic [ENTRIES-1:0] vld, freem;
  logic [SLOT_W:0]   rr, rr_v;
  logic [SLOT_W-1:0] idx, lowf, victim, win;
  logic [2:0]        op_q;
  logic [VA_W-1:0]   r_lo, r_hi;
  logic [PA_W-1:0]   r_pa;
  logic [ATTR_W-1:0] r_at;

  // range decode
  logic [7:0]      sh;
  logic [VA_W-1:0] vmask, c_lo, c_hi, p_lo, p_hi;
  logic [PA_W-1:0] pmask;
  logic            slot_ok, walk_op, kill, has_free;

  assign sh      = 8'(PG_BITS) + {3'b000, cmd_size, 1'b0};
  assign vmask   = ~({VA_W{1'b1}} << sh);
  assign pmask   = ~({PA_W{1'b1}} << sh);
  assign c_lo    = cmd_va & ~vmask;
  assign c_hi    = c_lo | vmask;
  assign p_lo    = cmd_va & ({VA_W{1'b1}} << PG_BITS);
  assign p_hi    = p_lo + (VA_W'(cmd_len) << PG_BITS) - VA_W'(1);
  assign slot_ok = int'(cmd_slot) < PINNED;
  assign walk_op = cmd_op == OP_INS || cmd_op == OP_PRG || cmd_op == OP_ALL || cmd_op == OP_PALL;
  assign busy    = st != S_IDLE;

  always_comb begin
    case (op_q)
      OP_INS, OP_PRG: kill = vld[idx] && int'(idx) >= PINNED &&
                             e_lo[idx] <= r_hi && e_hi[idx] >= r_lo;
      OP_ALL:         kill = int'(idx) >= PINNED;
      default:        kill = int'(idx) < PINNED;
    endcase
  end

  always_comb begin
    lowf = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (freem[i]) lowf = SLOT_W'(i);
  end
  assign has_free = |freem;
  assign rr_v     = (int'(rr) < PINNED || int'(rr) >= ENTRIES) ? (SLOT_W+1)'(PINNED) : rr;
  assign victim   = has_free ? lowf : rr_v[SLOT_W-1:0];

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; vld <= '0; freem <= UNPIN; rr <= (SLOT_W+1)'(PINNED);
      idx <= '0; op_q <= OP_INS; cmd_done <= 1'b0; cmd_err <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (walk_op) begin
            op_q <= cmd_op; idx <= '0; st <= S_WALK;
          end else begin
            cmd_done <= 1'b1;
            if ((cmd_op == OP_PINS || cmd_op == OP_PPRG) && slot_ok)
              vld[cmd_slot] <= (cmd_op == OP_PINS);
            else
              cmd_err <= 1'b1;
          end
        end
        S_WALK: begin
          if (kill) begin
            vld[idx] <= 1'b0;
            if (int'(idx) >= PINNED) freem[idx] <= 1'b1;
          end
          if (int'(idx) == ENTRIES - 1) st <= S_FIN;
          else idx <= idx + 1'b1;
        end
        default: begin
          if (op_q == OP_INS) begin
            vld[victim] <= 1'b1;
            freem[victim] <= 1'b0;
            if (!has_free) rr <= rr_v + 1'b1;
          end
          if (op_q == OP_ALL) rr <= (SLOT_W+1)'(PINNED);
          cmd_done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end

  // entry contents
  always_ff @(posedge clk) begin
    if (st == S_IDLE && cmd_valid) begin
      if (walk_op) begin
        r_lo <= c_lo; r_hi <= c_hi; r_pa <= cmd_pa & ~pmask; r_at <= cmd_attr;
      end else if (cmd_op == OP_PINS && slot_ok) begin
        e_lo[cmd_slot] <= p_lo;
        e_hi[cmd_slot] <= p_hi;
        e_pa[cmd_slot] <= cmd_pa & ({PA_W{1'b1}} << PG_BITS);
        e_at[cmd_slot] <= {cmd_attr[ATTR_W-1:2], 2'b01};
      end
    end else if (st == S_FIN && op_q == OP_INS) begin
      e_lo[victim] <= r_lo; e_hi[victim] <= r_hi;
      e_pa[victim] <= r_pa; e_at[victim] <= r_at;
    end
  end

  // parallel lookup
  logic [ENTRIES-1:0] hv;
  always_comb begin
    win = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hv[i] = vld[i] && lk_va >= e_lo[i] && lk_va <= e_hi[i];
      if (hv[i]) win = SLOT_W'(i);
    end
  end
  assign lk_hit  = (|hv) && !busy;
  assign lk_pa   = e_pa[win] + PA_W'(lk_va - e_lo[win]);
  assign lk_attr = e_at[win];

  // checks
  logic [SLOT_W+1:0] bcnt;
  always_ff @(posedge clk)
    if (!rst_n || !busy) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;

  assert_busy_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bcnt) <= ENTRIES + 1);
  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lk_hit);
  assert_pin_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WALK && op_q != OP_PALL) |=> vld[PINNED-1:0] == $past(vld[PINNED-1:0]));
  assert_free_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (freem & vld) == '0 && freem[PINNED-1:0] == '0);
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_done);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> !busy);
  assert_purge_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && op_q == OP_ALL) |=> (vld[ENTRIES-1:PINNED] == '0 && int'(rr) == PINNED));
endmodule

// File: tb/vr_tlb_test.sv
module vr_tlb_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_va = '0, cmd_pa = '0, lk_va = '0;
  logic [3:0] cmd_size = '0, cmd_slot = '0;
  logic [7:0] cmd_len = '0, cmd_attr = '0;
  logic busy, cmd_done, cmd_err, lk_hit;
  logic [31:0] lk_pa;
  logic [7:0] lk_attr;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vr_tlb uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_va(cmd_va), .cmd_pa(cmd_pa), .cmd_size(cmd_size), .cmd_slot(cmd_slot),
    .cmd_len(cmd_len), .cmd_attr(cmd_attr), .busy(busy), .cmd_done(cmd_done),
    .cmd_err(cmd_err), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr));

  // scoreboard queues
  logic        q_hit [$];
  logic [31:0] q_pa [$];
  logic [7:0]  q_at [$];
  logic        q_busy [$];
  string       q_tag [$];

  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      logic eh, eb; logic [31:0] ep; logic [7:0] ea; string t;
      eh = q_hit.pop_front(); ep = q_pa.pop_front(); ea = q_at.pop_front();
      eb = q_busy.pop_front(); t = q_tag.pop_front();
      checks++;
      if (lk_hit !== eh || busy !== eb || (eh && (lk_pa !== ep || lk_attr !== ea))) begin
        errors++;
        $display("FAIL %s va=%h actual hit=%b busy=%b pa=%h attr=%h expected hit=%b busy=%b pa=%h attr=%h",
                 t, lk_va, lk_hit, busy, lk_pa, lk_attr, eh, eb, ep, ea);
      end
    end
  end

  task automatic look(input logic [31:0] va, input logic eh, input logic [31:0] ep,
                      input logic [7:0] ea, input string tag, input logic eb = 1'b0);
    @(posedge clk); #1;
    lk_va = va;
    q_hit.push_back(eh); q_pa.push_back(ep); q_at.push_back(ea);
    q_busy.push_back(eb); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                       input logic [3:0] sz, input logic [3:0] slot, input logic [7:0] len,
                       input logic [7:0] at);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_pa = pa;
    cmd_size = sz; cmd_slot = slot; cmd_len = len; cmd_attr = at;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input logic exp_err, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (cmd_done) seen = 1'b1;
    end
    checks++;
    if (!seen || cmd_err !== exp_err) begin
      errors++;
      $display("FAIL %s done actual done=%b err=%b expected done=1 err=%b", tag, seen, cmd_err, exp_err);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] va, input logic [31:0] pa,
                     input logic [3:0] sz, input logic [3:0] slot, input logic [7:0] len,
                     input logic [7:0] at, input logic exp_err, input string tag);
    issue(op, va, pa, sz, slot, len, at);
    wait_done(exp_err, tag);
  endtask

  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (busy !== 1'b0 || cmd_done !== 1'b0) begin
      errors++;
      $display("FAIL reset R12 actual busy=%b done=%b expected 0 0", busy, cmd_done);
    end
    look(32'h0000_1000, 0, 0, 0, "R2 empty after reset");

    // R1 R2: 4 KiB and 64 KiB entries
    cmd(0, 32'h0001_2345, 32'h0008_0FFF, 0, 0, 0, 8'h5A, 0, "R1 insert small");
    look(32'h0001_2345, 1, 32'h0008_0345, 8'h5A, "R2 small page");
    cmd(0, 32'h0040_0000, 32'h0123_4567, 2, 0, 0, 8'h3C, 0, "R1 insert 64K");
    look(32'h0040_ABCD, 1, 32'h0123_ABCD, 8'h3C, "R1 64K aligned pa");
    look(32'h0041_0000, 0, 0, 0, "R1 past end");

    // R11: lookup and command during a walk
    issue(1, 32'h0001_2000, 0, 0, 0, 0, 0);
    look(32'h0040_ABCD, 0, 0, 0, "R11 stall while busy", 1'b1);
    issue(3, 32'h6000_0000, 32'h0600_0000, 0, 2, 1, 8'h00);
    wait_done(0, "R6 range purge");
    look(32'h0001_2345, 0, 0, 0, "R6 purged");
    look(32'h0040_ABCD, 1, 32'h0123_ABCD, 8'h3C, "R6 other kept");
    look(32'h6000_0000, 0, 0, 0, "R11 command ignored while busy");

    // R8: pinned insert forces T=0 D=1
    cmd(3, 32'h0020_0123, 32'h0900_0456, 0, 1, 3, 8'hF2, 0, "R8 pinned insert");
    look(32'h0020_2FFF, 1, 32'h0900_2FFF, 8'hF1, "R8 pinned last byte");
    look(32'h0020_3000, 0, 0, 0, "R8 pinned end");
    cmd(3, 32'h0, 32'h0, 0, 4, 1, 0, 1, "R9 slot out of range");
    cmd(4, 32'h0, 32'h0, 0, 7, 0, 0, 1, "R9 purge slot out of range");
    cmd(6, 32'h0, 32'h0, 0, 0, 0, 0, 1, "R9 unused opcode");
    look(32'h0040_ABCD, 1, 32'h0123_ABCD, 8'h3C, "R9 table unchanged");

    // R6 pinned survives range purge
    cmd(1, 32'h0020_1000, 0, 0, 0, 0, 0, 0, "R6 purge over pinned");
    look(32'h0020_0010, 1, 32'h0900_0010, 8'hF1, "R6 pinned survives");

    // R3 R4: overlap with pinned, lowest index wins
    cmd(0, 32'h0020_0000, 32'h0000_5000, 0, 0, 0, 8'h11, 0, "R4 insert over pinned");
    look(32'h0020_0010, 1, 32'h0900_0010, 8'hF1, "R3 lowest slot wins");
    cmd(0, 32'h0040_8000, 32'h0000_7000, 0, 0, 0, 8'h22, 0, "R4 insert over unpinned");
    look(32'h0040_ABCD, 0, 0, 0, "R4 overlapped flushed");
    look(32'h0040_8123, 1, 32'h0000_7123, 8'h22, "R4 new entry");

    // R7 purge-all
    cmd(2, 0, 0, 0, 0, 0, 0, 0, "R7 purge all");
    look(32'h0040_8123, 0, 0, 0, "R7 unpinned gone");
    look(32'h0020_0010, 1, 32'h0900_0010, 8'hF1, "R7 pinned kept");

    // R5 fill free slots then round-robin
    for (int k = 0; k < 12; k++)
      cmd(0, 32'h1000_0000 + (k << 12), 32'h0030_0000 + (k << 12), 0, 0, 0, 8'(k), 0, "R5 fill");
    look(32'h1000_B004, 1, 32'h0030_B004, 8'd11, "R5 last free slot");
    cmd(0, 32'h2000_0000, 32'h0050_0000, 0, 0, 0, 8'h77, 0, "R5 first victim");
    look(32'h1000_0004, 0, 0, 0, "R5 victim first unpinned");
    look(32'h1000_1004, 1, 32'h0030_1004, 8'd1, "R5 neighbour kept");
    look(32'h2000_0004, 1, 32'h0050_0004, 8'h77, "R5 new in victim");
    cmd(0, 32'h2000_1000, 32'h0050_1000, 0, 0, 0, 8'h78, 0, "R5 second victim");
    look(32'h1000_1004, 0, 0, 0, "R5 pointer advanced");
    look(32'h1000_2004, 1, 32'h0030_2004, 8'd2, "R5 next kept");

    // R10 pinned purges
    cmd(4, 0, 0, 0, 1, 0, 0, 0, "R10 pinned purge");
    look(32'h0020_0010, 0, 0, 0, "R10 pinned slot cleared");
    cmd(3, 32'h7000_0000, 32'h0A00_0000, 0, 0, 1, 8'h00, 0, "R8 pinned slot0");
    cmd(3, 32'h7100_0000, 32'h0B00_0000, 0, 3, 2, 8'h40, 0, "R8 pinned slot3");
    look(32'h7000_0FFC, 1, 32'h0A00_0FFC, 8'h01, "R8 slot0 hit");
    look(32'h7100_1FFC, 1, 32'h0B00_1FFC, 8'h41, "R8 slot3 hit");
    cmd(5, 0, 0, 0, 0, 0, 0, 0, "R10 pinned purge all");
    look(32'h7000_0FFC, 0, 0, 0, "R10 slot0 cleared");
    look(32'h7100_1FFC, 0, 0, 0, "R10 slot3 cleared");
    look(32'h1000_2004, 1, 32'h0030_2004, 8'd2, "R10 unpinned kept");

    // R1 full-width size code
    cmd(0, 32'h3456_7890, 32'hABCD_EF01, 15, 0, 0, 8'h33, 0, "R1 full range");
    look(32'h1234_5678, 1, 32'h1234_5678, 8'h33, "R1 full range pa");
    look(32'h1000_2004, 1, 32'h1000_2004, 8'h33, "R4 full range flushed others");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule